// File: doc/BRIEF.md
# Two-Hop Neighbourhood Walker

This engine takes one start vertex of an undirected graph and walks its two-hop neighbourhood in a single serial pass. For every neighbour `b` of the start vertex `a`, it visits every neighbour `c` of `b` and ignores any `c` that equals `a`. For each remaining triple it looks up one bit of an adjacency bit matrix to find out whether `c` is also connected to `a`. The triple is then counted as a closed triangle or as an open three-vertex chain, and the engine emits one counter-increment request tagged with the start vertex and a counter index.

The graph lives in an external word-addressed memory (64-bit words, word addresses) in three regions:
- **Pointer array** at `PTR_BASE`: `NUM_VERTS+1` entries. Entry `v` holds, in its low bits, the offset of the first neighbour of `v` inside the neighbour array. The neighbours of `v` run up to, but not including, the offset held in entry `v+1`.
- **Neighbour array** at `NBR_BASE`: one vertex index per word, with all lists packed back to back in vertex order.
- **Adjacency matrix** at `ADJ_BASE`: a row-major `NUM_VERTS x NUM_VERTS` bit matrix packed 64 bits per word.

The memory port is valid/ready on the request side, allows only one read in flight, and returns data on a one-cycle `mem_rsp_valid` strobe. A host or scheduler presents a vertex on the start handshake and waits for the `done` pulse. Many such engines can be placed side by side behind a shared memory switch.

Top module: `nbr_walk_engine`

FSM states and transitions:
- `ST_IDLE` → `ST_APTR_LO` when a start is taken.
- Pointer reads for `a`: `ST_APTR_LO` → `ST_APTR_LO_W` → `ST_APTR_HI` → `ST_APTR_HI_W` → `ST_B_CHECK`.
- `ST_B_CHECK` goes to `ST_DONE` when the `b` list is exhausted, otherwise to `ST_B_FETCH`.
- Fetching `b` and its pointers: `ST_B_FETCH` → `ST_B_FETCH_W` → `ST_BPTR_LO` → `ST_BPTR_LO_W` → `ST_BPTR_HI` → `ST_BPTR_HI_W` → `ST_C_CHECK`.
- `ST_C_CHECK` goes back to `ST_B_CHECK` (next `b`) when the `c` list is exhausted, otherwise to `ST_C_FETCH`.
- `ST_C_FETCH` → `ST_C_FETCH_W`, which returns to `ST_C_CHECK` when `c` equals `a`, otherwise goes to `ST_ADJ`.
- Adjacency test and increment: `ST_ADJ` → `ST_ADJ_W` → `ST_EMIT` → `ST_C_CHECK`.
- `ST_DONE` → `ST_IDLE`.
- Every request state (`ST_APTR_LO`, `ST_APTR_HI`, `ST_B_FETCH`, `ST_BPTR_LO`, `ST_BPTR_HI`, `ST_C_FETCH`, `ST_ADJ`) advances only when `mem_req_ready` is high.
- Every wait state (those ending in `_W`) advances only when `mem_rsp_valid` is high.

## Requirements
- R1: After reset `start_ready` is 1 and `done`, `inc_valid` and `mem_req_valid` are 0.
- R2: A start vertex is taken only while `start_ready` is high. While a walk is running, `start_ready` stays low and `start_valid` has no effect on the increments produced.
- R3: The neighbour list of vertex v is read from neighbour-array offsets `ptr[v]` up to `ptr[v+1]-1`, where `ptr[v]` is the low bits of pointer word `PTR_BASE+v`; an empty list (equal pointers) yields no work.
- R4: A second-hop vertex c equal to the start vertex a produces no increment.
- R5: Every increment carries `inc_vertex` equal to the start vertex and `inc_index` 1 for a triangle (c adjacent to a) or 0 for an open chain.
- R6: The adjacency test for (c, a) reads word `ADJ_BASE + (c*NUM_VERTS+a)/64` and uses bit `(c*NUM_VERTS+a) mod 64` of the returned data.
- R7: At most one read is in flight: no request is raised while a response is awaited. A request that is not yet accepted keeps `mem_req_valid` high and its address stable.
- R8: `done` is a one-cycle pulse after the last c of the last b, followed by `start_ready` high. A vertex with no neighbours gives `done` and no increments.
- R9: Increments appear in walk order: b in its list order, and, within each b, c in its list order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | Start vertex offered |
| start_vertex | input | VID_W | Start vertex index |
| start_ready | output | 1 | Engine idle and taking a start |
| done | output | 1 | One-cycle end-of-walk pulse |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Read request accepted |
| mem_req_addr | output | ADDR_W | Word address of the read |
| mem_rsp_valid | input | 1 | Read data strobe |
| mem_rsp_data | input | DATA_W | Read data |
| inc_valid | output | 1 | Counter-increment request strobe |
| inc_vertex | output | VID_W | Vertex whose counter is bumped |
| inc_index | output | CIDX_W | Counter index: 0 open chain, 1 triangle |

## Verification
The assertions assume the following about the environment:
- The memory model returns exactly one `mem_rsp_valid` strobe per accepted request, and never raises it when no read is outstanding.
- The graph image is well formed: pointers never decrease, and the neighbour lists are symmetric with the bit matrix.

The bench meets these assumptions by building the pointer, list and matrix regions from one edge list, and by making its memory model hold a single pending read. The model throttles `mem_req_ready` in a repeating pattern and varies the response delay with the address. This exercises the stall path (a request held while not accepted) without ever breaking the single-read rule.

// File: rtl/nbr_walk_pkg.sv
package nbr_walk_pkg;

    typedef enum logic [4:0] {
        ST_IDLE,
        ST_APTR_LO,
        ST_APTR_LO_W,
        ST_APTR_HI,
        ST_APTR_HI_W,
        ST_B_CHECK,
        ST_B_FETCH,
        ST_B_FETCH_W,
        ST_BPTR_LO,
        ST_BPTR_LO_W,
        ST_BPTR_HI,
        ST_BPTR_HI_W,
        ST_C_CHECK,
        ST_C_FETCH,
        ST_C_FETCH_W,
        ST_ADJ,
        ST_ADJ_W,
        ST_EMIT,
        ST_DONE
    } walk_state_e;

    typedef enum logic [2:0] {
        AK_PTR_A_LO,
        AK_PTR_A_HI,
        AK_NBR_B,
        AK_PTR_B_LO,
        AK_PTR_B_HI,
        AK_NBR_C,
        AK_ADJ
    } addr_kind_e;

endpackage

// File: rtl/nbr_walk_addr_gen.sv
module nbr_walk_addr_gen
    import nbr_walk_pkg::*;
#(
    parameter int NUM_VERTS = 16,
    parameter int VID_W     = 4,
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 64,
    parameter int PTR_BASE  = 0,
    parameter int NBR_BASE  = 32,
    parameter int ADJ_BASE  = 96
) (
    input  addr_kind_e                 kind,
    input  logic [VID_W-1:0]           vtx_a,
    input  logic [VID_W-1:0]           vtx_b,
    input  logic [VID_W-1:0]           vtx_c,
    input  logic [ADDR_W-1:0]          off_b,
    input  logic [ADDR_W-1:0]          off_c,
    output logic [ADDR_W-1:0]          addr,
    output logic [$clog2(DATA_W)-1:0]  bit_sel
);
    localparam int SEL_W = $clog2(DATA_W);
    localparam int BIT_W = 2 * VID_W + 2;

    logic [BIT_W-1:0] bit_idx;

    always_comb begin
        bit_idx = BIT_W'(vtx_c) * BIT_W'(NUM_VERTS) + BIT_W'(vtx_a);
        bit_sel = SEL_W'(bit_idx);
        unique case (kind)
            AK_PTR_A_LO: addr = ADDR_W'(PTR_BASE) + ADDR_W'(vtx_a);
            AK_PTR_A_HI: addr = ADDR_W'(PTR_BASE) + ADDR_W'(vtx_a) + ADDR_W'(1);
            AK_NBR_B:    addr = ADDR_W'(NBR_BASE) + off_b;
            AK_PTR_B_LO: addr = ADDR_W'(PTR_BASE) + ADDR_W'(vtx_b);
            AK_PTR_B_HI: addr = ADDR_W'(PTR_BASE) + ADDR_W'(vtx_b) + ADDR_W'(1);
            AK_NBR_C:    addr = ADDR_W'(NBR_BASE) + off_c;
            AK_ADJ:      addr = ADDR_W'(ADJ_BASE) + ADDR_W'(bit_idx >> SEL_W);
            default:     addr = '0;
        endcase
    end
endmodule

// File: rtl/nbr_walk_bit_pick.sv
module nbr_walk_bit_pick #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0]          word,
    input  logic [$clog2(DATA_W)-1:0]  sel,
    output logic                       bit_out
);
    always_comb bit_out = word[sel];
endmodule

// File: rtl/nbr_walk_engine.sv
module nbr_walk_engine
    import nbr_walk_pkg::*;
#(
    parameter int NUM_VERTS = 16,
    parameter int VID_W     = $clog2(NUM_VERTS),
    parameter int ADDR_W    = 10,
    parameter int DATA_W    = 64,
    parameter int CIDX_W    = 2,
    parameter int PTR_BASE  = 0,
    parameter int NBR_BASE  = 32,
    parameter int ADJ_BASE  = 96
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_valid,
    input  logic [VID_W-1:0]  start_vertex,
    output logic              start_ready,
    output logic              done,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rsp_data,
    output logic              inc_valid,
    output logic [VID_W-1:0]  inc_vertex,
    output logic [CIDX_W-1:0] inc_index
);
    localparam int SEL_W = $clog2(DATA_W);
    localparam logic [CIDX_W-1:0] CNT_OPEN = CIDX_W'(0);
    localparam logic [CIDX_W-1:0] CNT_TRI  = CIDX_W'(1);

    walk_state_e state, state_nx;
    addr_kind_e  kind;

    logic [VID_W-1:0]  a_q, b_q, c_q;
    logic [ADDR_W-1:0] b_off, b_end, c_off, c_end;
    logic              tri_q;
    logic [SEL_W-1:0]  bit_sel;
    logic              adj_bit;
    logic [ADDR_W-1:0] rsp_ptr;
    logic [VID_W-1:0]  rsp_vid;

    assign rsp_ptr = ADDR_W'(mem_rsp_data);
    assign rsp_vid = VID_W'(mem_rsp_data);

    nbr_walk_addr_gen #(
        .NUM_VERTS(NUM_VERTS), .VID_W(VID_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W),
        .PTR_BASE(PTR_BASE), .NBR_BASE(NBR_BASE), .ADJ_BASE(ADJ_BASE)
    ) u_addr (
        .kind(kind), .vtx_a(a_q), .vtx_b(b_q), .vtx_c(c_q),
        .off_b(b_off), .off_c(c_off), .addr(mem_req_addr), .bit_sel(bit_sel)
    );

    nbr_walk_bit_pick #(.DATA_W(DATA_W)) u_pick (
        .word(mem_rsp_data), .sel(bit_sel), .bit_out(adj_bit)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:      if (start_valid)   state_nx = ST_APTR_LO;
            ST_APTR_LO:   if (mem_req_ready) state_nx = ST_APTR_LO_W;
            ST_APTR_LO_W: if (mem_rsp_valid) state_nx = ST_APTR_HI;
            ST_APTR_HI:   if (mem_req_ready) state_nx = ST_APTR_HI_W;
            ST_APTR_HI_W: if (mem_rsp_valid) state_nx = ST_B_CHECK;
            ST_B_CHECK:   state_nx = (b_off == b_end) ? ST_DONE : ST_B_FETCH;
            ST_B_FETCH:   if (mem_req_ready) state_nx = ST_B_FETCH_W;
            ST_B_FETCH_W: if (mem_rsp_valid) state_nx = ST_BPTR_LO;
            ST_BPTR_LO:   if (mem_req_ready) state_nx = ST_BPTR_LO_W;
            ST_BPTR_LO_W: if (mem_rsp_valid) state_nx = ST_BPTR_HI;
            ST_BPTR_HI:   if (mem_req_ready) state_nx = ST_BPTR_HI_W;
            ST_BPTR_HI_W: if (mem_rsp_valid) state_nx = ST_C_CHECK;
            ST_C_CHECK:   state_nx = (c_off == c_end) ? ST_B_CHECK : ST_C_FETCH;
            ST_C_FETCH:   if (mem_req_ready) state_nx = ST_C_FETCH_W;
            ST_C_FETCH_W: if (mem_rsp_valid)
                              state_nx = (rsp_vid == a_q) ? ST_C_CHECK : ST_ADJ;
            ST_ADJ:       if (mem_req_ready) state_nx = ST_ADJ_W;
            ST_ADJ_W:     if (mem_rsp_valid) state_nx = ST_EMIT;
            ST_EMIT:      state_nx = ST_C_CHECK;
            ST_DONE:      state_nx = ST_IDLE;
            default:      state_nx = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Walk registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_q   <= '0;
            b_q   <= '0;
            c_q   <= '0;
            b_off <= '0;
            b_end <= '0;
            c_off <= '0;
            c_end <= '0;
            tri_q <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE:      if (start_valid)   a_q   <= start_vertex;
                ST_APTR_LO_W: if (mem_rsp_valid) b_off <= rsp_ptr;
                ST_APTR_HI_W: if (mem_rsp_valid) b_end <= rsp_ptr;
                ST_B_FETCH_W: if (mem_rsp_valid) b_q   <= rsp_vid;
                ST_BPTR_LO_W: if (mem_rsp_valid) c_off <= rsp_ptr;
                ST_BPTR_HI_W: if (mem_rsp_valid) c_end <= rsp_ptr;
                ST_C_CHECK:   if (c_off == c_end) b_off <= b_off + ADDR_W'(1);
                ST_C_FETCH_W: if (mem_rsp_valid) begin
                                  c_q <= rsp_vid;
                                  if (rsp_vid == a_q) c_off <= c_off + ADDR_W'(1);
                              end
                ST_ADJ_W:     if (mem_rsp_valid) tri_q <= adj_bit;
                ST_EMIT:      c_off <= c_off + ADDR_W'(1);
                default:      ;
            endcase
        end
    end

    // Outputs
    always_comb begin
        start_ready   = 1'b0;
        done          = 1'b0;
        inc_valid     = 1'b0;
        mem_req_valid = 1'b0;
        kind          = AK_PTR_A_LO;
        unique case (state)
            ST_IDLE:    start_ready = 1'b1;
            ST_APTR_LO: begin mem_req_valid = 1'b1; kind = AK_PTR_A_LO; end
            ST_APTR_HI: begin mem_req_valid = 1'b1; kind = AK_PTR_A_HI; end
            ST_B_FETCH: begin mem_req_valid = 1'b1; kind = AK_NBR_B;    end
            ST_BPTR_LO: begin mem_req_valid = 1'b1; kind = AK_PTR_B_LO; end
            ST_BPTR_HI: begin mem_req_valid = 1'b1; kind = AK_PTR_B_HI; end
            ST_C_FETCH: begin mem_req_valid = 1'b1; kind = AK_NBR_C;    end
            ST_ADJ:     begin mem_req_valid = 1'b1; kind = AK_ADJ;      end
            ST_EMIT:    inc_valid = 1'b1;
            ST_DONE:    done = 1'b1;
            default:    ;
        endcase
    end

    assign inc_vertex = a_q;
    assign inc_index  = tri_q ? CNT_TRI : CNT_OPEN;

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R7
    AST_NO_REQ_ON_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rsp_valid |-> !mem_req_valid); // R7
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (!done && start_ready)); // R8
    AST_NO_SELF_INC: assert property (@(posedge clk) disable iff (!rst_n)
        inc_valid |-> (c_q != a_q)); // R4
    AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(start_ready) |-> $past(start_valid)); // R2
endmodule

// File: tb/nbr_walk_engine_tb.sv
module nbr_walk_engine_tb;
    localparam int CLK_PERIOD = 10;
    localparam int NV     = 16;
    localparam int VW     = 4;
    localparam int AW     = 10;
    localparam int DW     = 64;
    localparam int CW     = 2;
    localparam int PTRB   = 0;
    localparam int NBRB   = 32;
    localparam int ADJB   = 96;
    localparam int MWORDS = 128;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_valid = 1'b0;
    logic [VW-1:0] start_vertex = '0;
    logic start_ready, done, mem_req_valid, inc_valid;
    logic mem_req_ready = 1'b0;
    logic [AW-1:0] mem_req_addr;
    logic mem_rsp_valid = 1'b0;
    logic [DW-1:0] mem_rsp_data = '0;
    logic [VW-1:0] inc_vertex;
    logic [CW-1:0] inc_index;

    int n_checks = 0;
    int n_fails  = 0;

    logic [DW-1:0] mem [MWORDS];
    logic adjm [NV][NV];
    int exp_v[$];
    int exp_k[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    nbr_walk_engine #(
        .NUM_VERTS(NV), .VID_W(VW), .ADDR_W(AW), .DATA_W(DW), .CIDX_W(CW),
        .PTR_BASE(PTRB), .NBR_BASE(NBRB), .ADJ_BASE(ADJB)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_vertex(start_vertex),
        .start_ready(start_ready), .done(done), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .inc_valid(inc_valid), .inc_vertex(inc_vertex), .inc_index(inc_index)
    );

    // Memory model: one pending read, address-dependent delay, throttled ready
    logic          pend = 1'b0;
    logic [AW-1:0] pend_addr = '0;
    logic [1:0]    lat = '0;
    logic [1:0]    rdy_ctr = '0;
    always @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0; mem_rsp_valid <= 1'b0; mem_req_ready <= 1'b0; rdy_ctr <= '0;
        end else begin
            rdy_ctr <= rdy_ctr + 2'd1;
            mem_req_ready <= (rdy_ctr != 2'd3);
            mem_rsp_valid <= 1'b0;
            if (mem_req_valid && mem_req_ready) begin
                pend <= 1'b1;
                pend_addr <= mem_req_addr;
                lat <= 2'(mem_req_addr % 3);
            end else if (pend) begin
                if (lat == 2'd0) begin
                    mem_rsp_valid <= 1'b1;
                    mem_rsp_data <= mem[int'(pend_addr) % MWORDS];
                    pend <= 1'b0;
                end else begin
                    lat <= lat - 2'd1;
                end
            end
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: pop expected increments in order
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_req_valid && pend)
                check(1'b0, "R7 request while read pending", 1, 0);
            if (inc_valid) begin
                if (exp_v.size() == 0) begin
                    check(1'b0, "R4 R9 unexpected increment", int'(inc_index), -1);
                end else begin
                    int ev, ek;
                    ev = exp_v.pop_front();
                    ek = exp_k.pop_front();
                    check(int'(inc_vertex) == ev, "R5 increment vertex tag", int'(inc_vertex), ev);
                    check(int'(inc_index) == ek, "R5 R6 R9 triangle/chain index", int'(inc_index), ek);
                end
            end
        end
    end

    task automatic add_edge(input int u, input int v);
        adjm[u][v] = 1'b1;
        adjm[v][u] = 1'b1;
    endtask

    task automatic build_graph();
        int p;
        for (int i = 0; i < MWORDS; i++) mem[i] = '0;
        for (int u = 0; u < NV; u++)
            for (int v = 0; v < NV; v++) adjm[u][v] = 1'b0;
        add_edge(0, 1);  add_edge(0, 2);  add_edge(1, 2);  add_edge(2, 3);
        add_edge(3, 4);  add_edge(6, 7);
        add_edge(8, 9);  add_edge(8, 10); add_edge(8, 11);
        add_edge(9, 10); add_edge(9, 11); add_edge(10, 11);
        add_edge(12, 13); add_edge(13, 14); add_edge(14, 15);
        add_edge(15, 12); add_edge(12, 14); add_edge(4, 15);
        p = 0;
        for (int v = 0; v < NV; v++) begin
            mem[PTRB + v] = DW'(p);
            for (int u = 0; u < NV; u++)
                if (adjm[v][u]) begin
                    mem[NBRB + p] = DW'(u);
                    p++;
                end
        end
        mem[PTRB + NV] = DW'(p);
        for (int c = 0; c < NV; c++)
            for (int a = 0; a < NV; a++)
                if (adjm[c][a]) mem[ADJB + (c*NV + a) / 64][(c*NV + a) % 64] = 1'b1;
    endtask

    task automatic run_walk(input int a, input bit poke_busy);
        int n_exp;
        int cyc;
        n_exp = 0;
        for (int b = 0; b < NV; b++)
            if (adjm[a][b])
                for (int c = 0; c < NV; c++)
                    if (adjm[b][c] && c != a) begin
                        exp_v.push_back(a);
                        exp_k.push_back(adjm[c][a] ? 1 : 0);
                        n_exp++;
                    end
        @(negedge clk);
        check(start_ready == 1'b1, "R8 ready before start", int'(start_ready), 1);
        start_valid = 1'b1;
        start_vertex = VW'(a);
        @(posedge clk);
        @(negedge clk);
        start_valid = 1'b0;
        if (poke_busy) begin
            // R2: offered start while busy must be ignored
            start_vertex = VW'(5);
            start_valid = 1'b1;
            for (int i = 0; i < 20; i++) begin
                if (start_ready) check(1'b0, "R2 ready while busy", 1, 0);
                @(negedge clk);
            end
            start_valid = 1'b0;
        end
        cyc = 0;
        while (!done && cyc < 20000) begin
            @(negedge clk);
            cyc++;
        end
        check(done == 1'b1, "R8 done raised", int'(done), 1);
        check(exp_v.size() == 0, "R3 R9 all increments seen", exp_v.size(), 0);
        exp_v.delete();
        exp_k.delete();
        @(negedge clk);
        check(done == 1'b0, "R8 done single cycle", int'(done), 0);
        check(start_ready == 1'b1, "R8 ready after done", int'(start_ready), 1);
        if (n_exp == 0) check(1'b1, "R8 empty-list vertex", 0, 0);
    endtask

    initial begin
        build_graph();
        repeat (3) @(posedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(start_ready == 1'b1, "R1 start_ready", int'(start_ready), 1);
        check(done == 1'b0, "R1 done", int'(done), 0);
        check(inc_valid == 1'b0, "R1 inc_valid", int'(inc_valid), 0);
        check(mem_req_valid == 1'b0, "R1 mem_req_valid", int'(mem_req_valid), 0);
        run_walk(0, 1'b0);   // triangle plus chains
        run_walk(5, 1'b0);   // isolated vertex, R8
        run_walk(6, 1'b0);   // leaf pair, only c==a, R4
        run_walk(8, 1'b1);   // clique, busy start ignored, R2
        run_walk(12, 1'b0);  // diamond
        run_walk(15, 1'b0);  // last matrix word
        run_walk(3, 1'b0);   // chains only
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule